// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel samples. The stream arrives as three wires: a bit clock, a framing (left/right) clock and a data line. All three are sampled by the system clock and pass through a short synchronizer. The receiver acts on each rising bit-clock edge it detects. A run-time format code picks how the framing clock is read. In left justified, right justified and I2S framing, its level names the channel. In the two DSP framings, its rising edge marks the start of a stereo frame, with the left word first and the right word straight after it.

A word-length code picks 16, 20, 24 or 32 bits. Words arrive most significant bit first. Each finished word is presented left-aligned in a 32-bit field, zero-filled below, together with a one-cycle strobe for its channel. Two error outputs exist. The first shows a format and length pair the receiver cannot handle; while it is shown, no samples are produced. The second is a sticky flag that is set when a framing period is shorter than the minimum for the chosen length.

Top module: `serial_audio_rx`

## Requirements
- R1: With fmt_sel = 0 (left justified), a word is the len bits whose first bit is sampled on the first bit-clock rise that sees a new frame_clk level. A high frame_clk marks the left channel.
- R2: With fmt_sel = 2 (I2S), the first bit of a word is sampled one bit clock later than in R1, and a low frame_clk marks the left channel.
- R3: With fmt_sel = 1 (right justified), a word is the last len bits sampled before a frame_clk change. It is issued on the bit-clock rise that sees the change, for the channel of the half that just ended (high = left). A half that began before the first observed change yields no sample.
- R4: With fmt_sel = 4 (DSP B), the left word starts on the bit-clock rise that first sees frame_clk high after low. With fmt_sel = 3 (DSP A), it starts one bit clock later. The right word follows the left word with no gap. The width of the sync pulse has no effect.
- R5: len_sel chooses the word length: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. Each sample is placed in the top bits of its 32-bit output, and the unused low bits read zero.
- R6: With fmt_sel = 1 and len_sel = 3, or with fmt_sel of 5 to 7, cfg_err is high and neither valid strobe pulses.
- R7: Each valid strobe is high for exactly one system-clock cycle, and the two strobes are never high together. A strobe rises three system-clock edges after the rising bit clock that completes its word.
- R8: frame_err is set and held when the bit-clock count between consecutive framing marks is below the limit. The marks are frame_clk changes in R1 to R3 modes, where the limit is len. In R4 modes they are rising edges, and the limit is 2*len. The interval before the first mark is not checked. A count exactly at the limit does not set the flag.
- R9: While rst_n is low, all outputs are zero, and frame_err clears only through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Serial bit clock, slower than clk |
| frame_clk | input | 1 | Left/right level or frame sync |
| ser_data | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 3 | Framing format code (see R1 to R4, R6) |
| len_sel | input | 2 | Word length code (see R5) |
| left_data | output | 32 | Last left sample, left-aligned |
| left_valid | output | 1 | One-cycle strobe for left_data |
| right_data | output | 32 | Last right sample, left-aligned |
| right_valid | output | 1 | One-cycle strobe for right_data |
| cfg_err | output | 1 | Unsupported format/length pair |
| frame_err | output | 1 | Sticky short-frame flag |

## Verification
Every sample strobe is due three system-clock edges after the bit-clock rise that completes its word. In right justified mode, that rise is the one that sees the framing change. The bench stamps the cycle count at every bit-clock rise it drives and checks that each strobe comes exactly three cycles later. Sample values and channel order are compared against words the bench placed in the stream itself. After the final bit of each stream the bench allows several idle bit periods, then reads frame_err and cfg_err, which settle within one cycle of the last marker.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  localparam int unsigned MAX_W = 32;
  localparam int unsigned REM_W = $clog2(2 * MAX_W + 1);

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  // word length code to bit count
  function automatic logic [REM_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return REM_W'(16);
      2'd1:    return REM_W'(20);
      2'd2:    return REM_W'(24);
      default: return REM_W'(32);
    endcase
  endfunction

  // move a right-aligned word to the top of the field
  function automatic logic [MAX_W-1:0] left_align(input logic [MAX_W-1:0] v,
                                                  input logic [1:0] code);
    return v << (MAX_W - 32'(word_bits(code)));
  endfunction

  // bits that must stay zero for a given length
  function automatic logic [MAX_W-1:0] tail_mask(input logic [1:0] code);
    return ~left_align('1, code);
  endfunction

  function automatic logic is_dsp(input logic [2:0] f);
    return (f == FMT_DSPA) || (f == FMT_DSPB);
  endfunction

  // formats whose MSB trails the framing mark by one bit clock
  function automatic logic late_msb(input logic [2:0] f);
    return (f == FMT_I2S) || (f == FMT_DSPA);
  endfunction

  function automatic logic cfg_illegal(input logic [2:0] f, input logic [1:0] code);
    return (f > FMT_DSPB) || ((f == FMT_RJ) && (code == 2'd3));
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_raw,
  input  logic lr_raw,
  input  logic dat_raw,
  output logic bit_stb,
  output logic bit_dat,
  output logic lr_lvl
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][2:0] stg;
  logic                   bclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg    <= '0;
      bclk_d <= 1'b0;
    end else begin
      stg[0] <= {bclk_raw, lr_raw, dat_raw};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      bclk_d <= stg[LAST][2];
    end
  end

  assign bit_stb = stg[LAST][2] & ~bclk_d;
  assign lr_lvl  = stg[LAST][1];
  assign bit_dat = stg[LAST][0];

endmodule

// File: rtl/sarx_mark.sv
module sarx_mark (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic lr_lvl,
  input  logic dsp,
  output logic lr_toggle,
  output logic lr_rise,
  output logic mark
);

  logic lr_prev;
  logic primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_prev <= 1'b0;
      primed  <= 1'b0;
    end else if (bit_stb) begin
      lr_prev <= lr_lvl;
      primed  <= 1'b1;
    end
  end

  assign lr_toggle = bit_stb & primed & (lr_lvl ^ lr_prev);
  assign lr_rise   = lr_toggle & lr_lvl;
  assign mark      = dsp ? lr_rise : lr_toggle;

endmodule

// File: rtl/sarx_asm.sv
module sarx_asm
  import sarx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             bit_dat,
  input  logic             lr_lvl,
  input  logic             mark,
  input  logic [2:0]       fmt,
  input  logic [1:0]       len,
  input  logic             bad,
  output logic             emit_l,
  output logic             emit_r,
  output logic [MAX_W-1:0] emit_word
);

  logic [REM_W-1:0] wbits, rem, rem_n, load_cnt;
  logic             dsp, late, rj;
  logic             active, chan, pend, pend_chan, seen;
  logic [MAX_W-1:0] sh, shifted, rj_sh;
  logic             new_chan, start_now;
  logic             slot_fire, slot_l_done, slot_r_done, rj_fire;

  assign wbits    = word_bits(len);
  assign dsp      = is_dsp(fmt);
  assign late     = late_msb(fmt);
  assign rj       = (fmt == FMT_RJ);
  assign load_cnt = (dsp ? {wbits[REM_W-2:0], 1'b0} : wbits) - REM_W'(1);

  assign shifted  = {sh[MAX_W-2:0], bit_dat};
  assign rem_n    = rem - REM_W'(1);

  // channel of a word that begins at this mark (1 = left)
  assign new_chan = dsp ? 1'b1 : ((fmt == FMT_I2S) ? ~lr_lvl : lr_lvl);

  assign slot_fire   = bit_stb & active & ~rj;
  assign slot_l_done = slot_fire & (dsp ? (rem_n == wbits) : ((rem_n == '0) & chan));
  assign slot_r_done = slot_fire & (dsp ? (rem_n == '0)    : ((rem_n == '0) & ~chan));
  assign rj_fire     = bit_stb & rj & mark & seen;
  assign start_now   = bit_stb & ~rj & ((mark & ~late) | pend);

  // right justified: the half that ended had the opposite level
  assign emit_l    = ~bad & (slot_l_done | (rj_fire & ~lr_lvl));
  assign emit_r    = ~bad & (slot_r_done | (rj_fire & lr_lvl));
  assign emit_word = rj ? left_align(rj_sh, len) : left_align(shifted, len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rj_sh     <= '0;
      seen      <= 1'b0;
      pend      <= 1'b0;
      pend_chan <= 1'b0;
    end else if (bit_stb) begin
      rj_sh <= {rj_sh[MAX_W-2:0], bit_dat};
      pend  <= mark & late & ~rj;
      if (mark) begin
        seen      <= 1'b1;
        pend_chan <= new_chan;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      chan   <= 1'b0;
      rem    <= '0;
      sh     <= '0;
    end else if (start_now) begin
      active <= 1'b1;
      chan   <= pend ? pend_chan : new_chan;
      rem    <= load_cnt;
      sh     <= {{(MAX_W-1){1'b0}}, bit_dat};
    end else if (slot_fire) begin
      rem <= rem_n;
      sh  <= (dsp && (rem_n == wbits)) ? '0 : shifted;
      if (rem_n == '0) active <= 1'b0;
    end
  end

endmodule

// File: rtl/sarx_span.sv
module sarx_span
  import sarx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       mark,
  input  logic       dsp,
  input  logic [1:0] len,
  output logic       frame_err
);

  logic [CNT_W-1:0] cnt, lim;
  logic [REM_W-1:0] wbits;
  logic             armed;
  logic             too_short;

  assign wbits     = word_bits(len);
  assign lim       = dsp ? CNT_W'({wbits, 1'b0}) : CNT_W'(wbits);
  assign too_short = bit_stb & mark & armed & (cnt < lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      armed     <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (too_short) frame_err <= 1'b1;
      if (bit_stb) begin
        if (mark) begin
          cnt   <= CNT_W'(1);
          armed <= 1'b1;
        end else if (cnt != '1) begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SPAN_CNT_W  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_clk,
  input  logic        frame_clk,
  input  logic        ser_data,
  input  logic [2:0]  fmt_sel,
  input  logic [1:0]  len_sel,
  output logic [31:0] left_data,
  output logic        left_valid,
  output logic [31:0] right_data,
  output logic        right_valid,
  output logic        cfg_err,
  output logic        frame_err
);

  logic             bit_stb, bit_dat, lr_lvl;
  logic             lr_toggle, lr_rise, mark;
  logic             dsp, bad;
  logic             emit_l, emit_r;
  logic [MAX_W-1:0] emit_word;

  assign dsp = is_dsp(fmt_sel);
  assign bad = cfg_illegal(fmt_sel, len_sel);

  sarx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .bclk_raw(bit_clk), .lr_raw(frame_clk), .dat_raw(ser_data),
    .bit_stb(bit_stb), .bit_dat(bit_dat), .lr_lvl(lr_lvl)
  );

  sarx_mark mark_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .lr_lvl(lr_lvl), .dsp(dsp),
    .lr_toggle(lr_toggle), .lr_rise(lr_rise), .mark(mark)
  );

  sarx_asm asm_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_dat(bit_dat),
    .lr_lvl(lr_lvl), .mark(mark), .fmt(fmt_sel), .len(len_sel), .bad(bad),
    .emit_l(emit_l), .emit_r(emit_r), .emit_word(emit_word)
  );

  sarx_span #(.CNT_W(SPAN_CNT_W)) span_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .mark(mark), .dsp(dsp),
    .len(len_sel), .frame_err(frame_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_data   <= '0;
      right_data  <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      left_valid  <= emit_l;
      right_valid <= emit_r;
      cfg_err     <= bad;
      if (emit_l) left_data  <= emit_word;
      if (emit_r) right_data <= emit_word;
    end
  end

endmodule

// File: rtl/sarx_chk.sv
module sarx_chk
  import sarx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  len_sel,
  input logic        bit_stb,
  input logic        left_valid,
  input logic        right_valid,
  input logic [31:0] left_data,
  input logic [31:0] right_data,
  input logic        cfg_err,
  input logic        frame_err
);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({left_valid, right_valid}));

  // R7
  left_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |=> !left_valid);

  // R7
  right_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |=> !right_valid);

  // R7
  strobe_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid) |-> $past(bit_stb));

  // R6
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(left_valid || right_valid));

  // R8
  frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R5
  left_tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |-> ((left_data & tail_mask($past(len_sel))) == '0));

  // R5
  right_tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |-> ((right_data & tail_mask($past(len_sel))) == '0));

endmodule

bind serial_audio_rx sarx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .bit_stb(bit_stb),
  .left_valid(left_valid), .right_valid(right_valid),
  .left_data(left_data), .right_data(right_data),
  .cfg_err(cfg_err), .frame_err(frame_err)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_clk = 1'b0, frame_clk = 1'b0, ser_data = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic [1:0]  len_sel = 2'd0;
  logic [31:0] left_data, right_data;
  logic        left_valid, right_valid, cfg_err, frame_err;

  always #10 clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .ser_data(ser_data), .fmt_sel(fmt_sel), .len_sel(len_sel),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid),
    .cfg_err(cfg_err), .frame_err(frame_err)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0, last_rise = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit          lr_a [512];
  bit          d_a  [512];
  int          slen;
  logic [31:0] exp_d [8];
  bit          exp_c [8];
  int          n_exp;
  logic [31:0] rx_d [16];
  bit          rx_c [16];
  int          rx_l [16];
  int          n_rx = 0;

  // capture every strobe with its channel and delay from the last bit-clock rise
  always @(negedge clk) begin
    if (rst_n && left_valid && n_rx < 16) begin
      rx_d[n_rx] = left_data; rx_c[n_rx] = 1'b1; rx_l[n_rx] = cyc - last_rise; n_rx++;
    end
    if (rst_n && right_valid && n_rx < 16) begin
      rx_d[n_rx] = right_data; rx_c[n_rx] = 1'b0; rx_l[n_rx] = cyc - last_rise; n_rx++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string fmt_tag(input int f);
    case (f)
      0: return "R1";
      1: return "R3";
      2: return "R2";
      default: return "R4";
    endcase
  endfunction

  function automatic int len_of(input int w);
    return (w == 3) ? 32 : 16 + 4 * w;
  endfunction

  function automatic logic [31:0] pat(input int seed, input int k, input int wb);
    logic [63:0] x;
    logic [31:0] m;
    x = 64'(seed) * 64'h9E3779B97F4A7C15 + 64'(k + 1) * 64'hC2B2AE3D27D4EB4F;
    x = x ^ (x >> 29);
    m = (wb == 32) ? 32'hFFFF_FFFF : ((32'd1 << wb) - 32'd1);
    return x[31:0] & m;
  endfunction

  task automatic place(input int off, input logic [31:0] v, input int wb);
    for (int i = 0; i < wb; i++) d_a[off + i] = v[wb - 1 - i];
  endtask

  task automatic push_exp(input logic [31:0] v, input int wb, input bit left);
    exp_d[n_exp] = v << (32 - wb);
    exp_c[n_exp] = left;
    n_exp++;
  endtask

  // lay out two stereo frames with a lead-in and a tail
  task automatic build(input int f, input int w, input int span, input int pw, input int seed);
    int wb, b, off;
    bit lvl_l;
    logic [31:0] v;
    wb = len_of(w);
    n_exp = 0;
    for (int i = 0; i < 512; i++) begin lr_a[i] = 1'b0; d_a[i] = 1'b0; end
    if (f == 3 || f == 4) begin
      slen = 4 + 2 * span + 4;
      for (int fr = 0; fr < 2; fr++)
        for (int k = 0; k < pw; k++) lr_a[4 + fr * span + k] = 1'b1;
      for (int fr = 0; fr < 2; fr++) begin
        b = 4 + fr * span;
        off = b + ((f == 3) ? 1 : 0);
        v = pat(seed, 2 * fr, wb);     place(off, v, wb);      push_exp(v, wb, 1'b1);
        v = pat(seed, 2 * fr + 1, wb); place(off + wb, v, wb); push_exp(v, wb, 1'b0);
      end
    end else begin
      lvl_l = (f == 2) ? 1'b0 : 1'b1;
      slen = 4 + 4 * span + 4;
      for (int i = 0; i < slen; i++) lr_a[i] = lvl_l;
      for (int i = 0; i < 4; i++) lr_a[i] = ~lvl_l;
      for (int h = 1; h < 4; h += 2)
        for (int i = 0; i < span; i++) lr_a[4 + h * span + i] = ~lvl_l;
      for (int h = 0; h < 4; h++) begin
        b = 4 + h * span;
        off = (f == 2) ? b + 1 : (f == 1) ? b + span - wb : b;
        v = pat(seed, h, wb);
        place(off, v, wb);
        push_exp(v, wb, (h % 2) == 0);
      end
    end
  endtask

  task automatic start(input int f, input int w);
    fmt_sel = 3'(f); len_sel = 2'(w);
    rst_n = 1'b0; bit_clk = 1'b0; frame_clk = lr_a[0]; ser_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_rx = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic stream();
    for (int i = 0; i < slen; i++) begin
      bit_clk = 1'b0; frame_clk = lr_a[i]; ser_data = d_a[i];
      repeat (4) @(negedge clk);
      bit_clk = 1'b1; last_rise = cyc;
      repeat (4) @(negedge clk);
    end
    bit_clk = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic run_ok(input int f, input int w, input int span, input int pw, input int seed);
    string tg;
    int wb;
    logic [31:0] tm;
    tg = fmt_tag(f);
    wb = len_of(w);
    tm = (wb == 32) ? 32'd0 : ((32'd1 << (32 - wb)) - 32'd1);
    build(f, w, span, pw, seed);
    start(f, w);
    stream();
    check(n_rx == n_exp, tg, "sample count", 32'(n_rx), 32'(n_exp));
    for (int k = 0; k < n_exp && k < n_rx; k++) begin
      check(rx_d[k] == exp_d[k], tg, "sample value", rx_d[k], exp_d[k]);
      check(rx_c[k] == exp_c[k], tg, "channel (1=left)", 32'(rx_c[k]), 32'(exp_c[k]));
      check((rx_d[k] & tm) == 32'd0, "R5", "zero tail", rx_d[k] & tm, 32'd0);
      check(rx_l[k] == 3, "R7", "strobe delay", 32'(rx_l[k]), 32'd3);
    end
    check(frame_err == 1'b0, "R8", "no error at or above limit", 32'(frame_err), 32'd0);
    check(cfg_err == 1'b0, "R6", "legal pair", 32'(cfg_err), 32'd0);
  endtask

  initial begin
    // R9: outputs held at zero during reset
    build(0, 0, 16, 1, 1);
    fmt_sel = 3'd0; len_sel = 2'd0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check({left_valid, right_valid, cfg_err, frame_err} == 4'd0, "R9", "reset flags",
          32'({left_valid, right_valid, cfg_err, frame_err}), 32'd0);
    check(left_data == 32'd0 && right_data == 32'd0, "R9", "reset data",
          left_data | right_data, 32'd0);

    // sweep formats and lengths at the minimum and above it
    for (int f = 0; f < 5; f++)
      for (int w = 0; w < 4; w++) begin
        if (f == 1 && w == 3) continue;
        if (f >= 3) begin
          run_ok(f, w, 2 * len_of(w), 1, f * 10 + w);
          run_ok(f, w, 2 * len_of(w) + 5, 3, f * 10 + w + 100);
        end else begin
          run_ok(f, w, len_of(w), 1, f * 10 + w);
          run_ok(f, w, len_of(w) + 3, 1, f * 10 + w + 100);
        end
      end

    // R6: unsupported pairs stay silent
    build(1, 3, 32, 1, 7); start(1, 3); stream();
    check(cfg_err == 1'b1, "R6", "rj 32 flagged", 32'(cfg_err), 32'd1);
    check(n_rx == 0, "R6", "rj 32 no samples", 32'(n_rx), 32'd0);
    build(6, 0, 16, 1, 8); start(6, 0); stream();
    check(cfg_err == 1'b1, "R6", "code 6 flagged", 32'(cfg_err), 32'd1);
    check(n_rx == 0, "R6", "code 6 no samples", 32'(n_rx), 32'd0);

    // R8: short halves, sticky, cleared by reset (R9)
    build(0, 0, 15, 1, 9); start(0, 0); stream();
    check(frame_err == 1'b1, "R8", "half below len", 32'(frame_err), 32'd1);
    repeat (40) @(negedge clk);
    check(frame_err == 1'b1, "R8", "flag held", 32'(frame_err), 32'd1);
    build(4, 1, 39, 1, 10); start(4, 1);
    check(frame_err == 1'b0, "R9", "reset clears flag", 32'(frame_err), 32'd0);
    stream();
    check(frame_err == 1'b1, "R8", "dsp period below 2*len", 32'(frame_err), 32'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule